// File: doc/BRIEF.md
# I2C Master Interrupt Status and Mask Unit

This unit gathers the completion, error and FIFO service conditions of an I2C master transfer engine into one master status register. Each status bit has its own enable bit in a master enable register. When any enabled status bit is set, a master summary flag rises in a top-level status register. That register also carries a slave summary level. A top-level enable register selects which summary flags may raise the single registered interrupt line.

Completion and error conditions arrive as one-cycle pulses and are held until software clears them by writing 1. The two FIFO service bits are levels that follow their inputs. The master summary flag is kept by a two-state machine. In state SUM_IDLE it moves to SUM_PEND (transition "raise") on the first cycle in which the masked status is nonzero. In SUM_PEND it returns to SUM_IDLE (transition "acknowledge") when software writes 1 to top-status bit 0 and the masked status is zero in that same cycle. In every other case it stays where it is ("hold"). A combined error output reports whether any error bit is set. Software reaches the four registers through a write port and a separate combinational read port.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and both `irq_o` and `err_any_o` are 0. The registers are selected by word address: 0 top status, 1 top enable, 2 master enable, 3 master status.
- R2: A one-cycle pulse on an event input sets its master status bit on the next clock edge, and the bit stays set afterwards. The bit positions are: nak_addr 4, nak_data 5, arb_lost 6, timeout 7, bad_param 8, stop_done 9, auto_done 10, man_done 11.
- R3: Writing to the master status register clears each event bit whose written bit is 1. Bits written 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: Master status bit 13 follows `rx_svc_i` and bit 12 follows `tx_svc_i`, one clock edge later. Writes to these bits have no effect.
- R6: The master enable register stores bits 13:4 as written and reads them back.
- R7: Top-status bit 0 is set one clock edge after (master status AND master enable) becomes nonzero. It stays set until a write of 1 to top-status bit 0. That write has no effect while the masked status is still nonzero.
- R8: Top-status bit 1 follows `slv_sum_i`, one clock edge later.
- R9: `irq_o` is a registered, active-high level. It equals the OR of (top status AND top enable bits 1:0), one clock edge later than the top status.
- R10: `err_any_o` is 1 exactly when any of master status bits 8:4 is set.
- R11: Unmapped bits read 0 and ignore writes. These are master status and enable bits 15:14 and 3:0, and top status and enable bits 15:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_svc_i | input | 1 | Receive FIFO needs service (level) |
| tx_svc_i | input | 1 | Transmit FIFO needs service (level) |
| man_done_i | input | 1 | Manual-mode transfer done pulse |
| auto_done_i | input | 1 | Automatic-mode transfer done pulse |
| stop_done_i | input | 1 | Stop condition complete pulse |
| bad_param_i | input | 1 | Invalid parameter pulse |
| timeout_i | input | 1 | Bus timeout pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| nak_data_i | input | 1 | NAK in data phase pulse |
| nak_addr_i | input | 1 | NAK in address phase pulse |
| slv_sum_i | input | 1 | Slave summary level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write word address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read word address |
| rd_data_o | output | 16 | Register read data (combinational) |
| err_any_o | output | 1 | Any error status bit set |
| irq_o | output | 1 | Interrupt request, registered level |

## Verification
An event pulse captured at edge k appears in the master status after edge k. The top-status summary bit follows after edge k+1, and `irq_o` after edge k+2. A level change on the slave or FIFO input shows in its status bit after the edge that captures it. A top-enable write reaches `irq_o` one edge after it lands. Every check in the bench waits for exactly one falling clock edge and is then compared by the monitor just after it. A chain of checks therefore walks through these due cycles one edge at a time and tests both the cycle before each result is due and the cycle in which it arrives.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int TOP_W  = 2;

    // master status bit positions (decoded by the transfer engine and software)
    localparam int B_NAK_ADDR  = 4;
    localparam int B_NAK_DATA  = 5;
    localparam int B_ARB_LOST  = 6;
    localparam int B_TIMEOUT   = 7;
    localparam int B_BAD_PARAM = 8;
    localparam int B_STOP_DONE = 9;
    localparam int B_AUTO_DONE = 10;
    localparam int B_MAN_DONE  = 11;
    localparam int B_TX_SVC    = 12;
    localparam int B_RX_SVC    = 13;

    localparam logic [DATA_W-1:0] STICKY_MASK = 16'h0FF0;
    localparam logic [DATA_W-1:0] LEVEL_MASK  = 16'h3000;
    localparam logic [DATA_W-1:0] ERR_MASK    = 16'h01F0;
    localparam logic [DATA_W-1:0] MAP_MASK    = STICKY_MASK | LEVEL_MASK;

    typedef enum logic [ADDR_W-1:0] {
        REG_TOP_STAT = 2'd0,
        REG_TOP_EN   = 2'd1,
        REG_MST_EN   = 2'd2,
        REG_MST_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SUM_IDLE = 1'b0,
        SUM_PEND = 1'b1
    } sum_state_e;
endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              clr_we_i,
    input  logic              en_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] enable_o,
    output logic              hit_o,
    output logic              err_o
);
    logic [DATA_W-1:0] en_q;
    logic              unused_bits;

    assign unused_bits = ^(src_i & ~MAP_MASK);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_i[i] | (bit_q & ~(clr_we_i & wdata_i[i]));
            end
            assign status_o[i] = bit_q;
        end else if (LEVEL_MASK[i]) begin : g_level
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_i[i];
            end
            assign status_o[i] = bit_q;
        end else begin : g_none
            assign status_o[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= wdata_i & MAP_MASK;
    end

    assign enable_o = en_q;
    assign hit_o    = |(status_o & en_q);
    assign err_o    = |(status_o & ERR_MASK);

    logic past_valid;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R2 and R4: an event always sets its bit, even against a clearing write
    a_r2_event_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & STICKY_MASK)) |=>
            ((status_o & $past(src_i & STICKY_MASK)) == $past(src_i & STICKY_MASK)));

    a_r3_clear_wins_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && |(wdata_i & STICKY_MASK & ~src_i)) |=>
            ((status_o & $past(wdata_i & STICKY_MASK & ~src_i)) == '0));

    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> ((status_o & LEVEL_MASK) == $past(src_i & LEVEL_MASK)));
endmodule

// File: rtl/i2c_irq_summary.sv
module i2c_irq_summary
    import i2c_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic ack_i,
    output logic pend_o
);
    sum_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE: if (hit_i)           state_d = SUM_PEND;  // raise
            SUM_PEND: if (ack_i && !hit_i) state_d = SUM_IDLE;  // acknowledge
            default:                       state_d = SUM_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SUM_PEND: pend_o = 1'b1;
            default:  pend_o = 1'b0;
        endcase
    end

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> pend_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_svc_i,
    input  logic              tx_svc_i,
    input  logic              man_done_i,
    input  logic              auto_done_i,
    input  logic              stop_done_i,
    input  logic              bad_param_i,
    input  logic              timeout_i,
    input  logic              arb_lost_i,
    input  logic              nak_data_i,
    input  logic              nak_addr_i,
    input  logic              slv_sum_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              err_any_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] mst_stat, mst_en;
    logic              hit, pend;
    logic              slv_q, irq_q;
    logic [TOP_W-1:0]  top_en_q, top_stat;
    logic              wr_top_stat, wr_top_en, wr_mst_en, wr_mst_stat;

    always_comb begin
        src              = '0;
        src[B_NAK_ADDR]  = nak_addr_i;
        src[B_NAK_DATA]  = nak_data_i;
        src[B_ARB_LOST]  = arb_lost_i;
        src[B_TIMEOUT]   = timeout_i;
        src[B_BAD_PARAM] = bad_param_i;
        src[B_STOP_DONE] = stop_done_i;
        src[B_AUTO_DONE] = auto_done_i;
        src[B_MAN_DONE]  = man_done_i;
        src[B_TX_SVC]    = tx_svc_i;
        src[B_RX_SVC]    = rx_svc_i;
    end

    assign wr_top_stat = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_TOP_STAT);
    assign wr_top_en   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_TOP_EN);
    assign wr_mst_en   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_MST_EN);
    assign wr_mst_stat = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_MST_STAT);

    i2c_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .clr_we_i (wr_mst_stat),
        .en_we_i  (wr_mst_en),
        .wdata_i  (wr_data_i),
        .status_o (mst_stat),
        .enable_o (mst_en),
        .hit_o    (hit),
        .err_o    (err_any_o)
    );

    i2c_irq_summary u_summary (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .ack_i  (wr_top_stat && wr_data_i[0]),
        .pend_o (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q    <= 1'b0;
            top_en_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            slv_q <= slv_sum_i;
            if (wr_top_en) top_en_q <= wr_data_i[TOP_W-1:0];
            irq_q <= |(top_stat & top_en_q);
        end
    end

    assign top_stat = {slv_q, pend};
    assign irq_o    = irq_q;

    always_comb begin
        unique case (reg_sel_e'(rd_addr_i))
            REG_TOP_STAT: rd_data_o = {{(DATA_W-TOP_W){1'b0}}, top_stat};
            REG_TOP_EN:   rd_data_o = {{(DATA_W-TOP_W){1'b0}}, top_en_q};
            REG_MST_EN:   rd_data_o = mst_en;
            REG_MST_STAT: rd_data_o = mst_stat;
            default:      rd_data_o = '0;
        endcase
    end

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(top_en_q) != '0));

    a_r8_slave_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        slv_sum_i |=> top_stat[1]);

    a_r10_err_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_any_o |-> ((mst_stat & ERR_MASK) != '0));
endmodule

// File: tb/test_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module test_i2c_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_svc = 0, tx_svc = 0, man_done = 0, auto_done = 0, stop_done = 0;
    logic        bad_param = 0, timeout = 0, arb_lost = 0, nak_data = 0, nak_addr = 0;
    logic        slv_sum = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [1:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic        err_any, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 register, 1 irq, 2 err
        logic [1:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    i2c_irq_ctrl i_i2c_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_svc_i(rx_svc), .tx_svc_i(tx_svc), .man_done_i(man_done),
        .auto_done_i(auto_done), .stop_done_i(stop_done), .bad_param_i(bad_param),
        .timeout_i(timeout), .arb_lost_i(arb_lost), .nak_data_i(nak_data),
        .nak_addr_i(nak_addr), .slv_sum_i(slv_sum),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .err_any_o(err_any), .irq_o(irq)
    );

    // monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                rd_addr = it.addr;
                #1;
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {15'b0, irq};
                    default: act = {15'b0, err_any};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: kind=%0d addr=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int kind, input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 0;
    endtask

    task automatic drive_ev(input logic [15:0] m);
        nak_addr = m[4]; nak_data = m[5]; arb_lost = m[6]; timeout = m[7];
        bad_param = m[8]; stop_done = m[9]; auto_done = m[10]; man_done = m[11];
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        drive_ev(m);
        @(posedge clk);
        #1 drive_ev(16'h0);
    endtask

    task automatic pulse_with_write(input logic [15:0] m, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        drive_ev(m);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 drive_ev(16'h0);
        wr_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        chk(0, 2'd0, 16'h0000, "R1 top status");
        chk(0, 2'd1, 16'h0000, "R1 top enable");
        chk(0, 2'd2, 16'h0000, "R1 master enable");
        chk(0, 2'd3, 16'h0000, "R1 master status");
        chk(1, 2'd0, 16'h0000, "R1 irq");
        chk(2, 2'd0, 16'h0000, "R1 err");

        // R6 / R11 enable storage
        do_write(2'd2, 16'hFFFF);
        chk(0, 2'd2, 16'h3FF0, "R6 R11 master enable mapped bits");
        do_write(2'd2, 16'h0000);
        chk(0, 2'd2, 16'h0000, "R6 master enable cleared");

        // R2 single event, R10 error group
        pulse(16'h0010);
        chk(0, 2'd3, 16'h0010, "R2 nak_addr sets bit 4");
        chk(2, 2'd0, 16'h0001, "R10 err from nak_addr");
        chk(0, 2'd0, 16'h0000, "R7 no summary when masked");
        chk(1, 2'd0, 16'h0000, "R9 no irq when masked");

        // R2 all other events at once
        pulse(16'h0FE0);
        chk(0, 2'd3, 16'h0FF0, "R2 all event bits");

        // R3 clearing
        do_write(2'd3, 16'h0000);
        chk(0, 2'd3, 16'h0FF0, "R3 write zero keeps bits");
        do_write(2'd3, 16'h00F0);
        chk(0, 2'd3, 16'h0F00, "R3 clear low bits");
        chk(2, 2'd0, 16'h0001, "R10 err from bad_param");
        do_write(2'd3, 16'h0100);
        chk(0, 2'd3, 16'h0E00, "R3 clear bad_param");
        chk(2, 2'd0, 16'h0000, "R10 err drops");

        // R4 collision
        pulse_with_write(16'h0200, 2'd3, 16'h0200);
        chk(0, 2'd3, 16'h0E00, "R4 event beats clear");
        do_write(2'd3, 16'h0E00);
        chk(0, 2'd3, 16'h0000, "R3 clear remaining");

        // R5 FIFO levels
        @(negedge clk); rx_svc = 1;
        chk(0, 2'd3, 16'h2000, "R5 rx level");
        do_write(2'd3, 16'h3000);
        chk(0, 2'd3, 16'h2000, "R5 write ignored on level");
        @(negedge clk); rx_svc = 0; tx_svc = 1;
        chk(0, 2'd3, 16'h1000, "R5 tx level");
        @(negedge clk); tx_svc = 0;
        chk(0, 2'd3, 16'h0000, "R5 levels drop");

        // R7 / R9 summary and irq timing
        do_write(2'd2, 16'h0080);
        do_write(2'd1, 16'h0001);
        pulse(16'h0080);
        chk(0, 2'd0, 16'h0000, "R7 summary not yet");
        chk(1, 2'd0, 16'h0000, "R9 irq not yet");
        chk(1, 2'd0, 16'h0001, "R9 irq raised");
        chk(0, 2'd0, 16'h0001, "R7 summary set");
        do_write(2'd0, 16'h0001);
        chk(0, 2'd0, 16'h0001, "R7 ack ignored while masked status set");
        do_write(2'd3, 16'h0080);
        chk(0, 2'd3, 16'h0000, "R3 timeout cleared");
        chk(0, 2'd0, 16'h0001, "R7 summary holds");
        do_write(2'd0, 16'h0001);
        chk(0, 2'd0, 16'h0000, "R7 summary acknowledged");
        chk(1, 2'd0, 16'h0000, "R9 irq drops");

        // R8 / R9 top enable gating with level source
        do_write(2'd1, 16'h0000);
        do_write(2'd2, 16'h2000);
        @(negedge clk); rx_svc = 1;
        chk(0, 2'd3, 16'h2000, "R5 rx level again");
        chk(0, 2'd0, 16'h0001, "R7 summary from level");
        chk(1, 2'd0, 16'h0000, "R9 irq masked by top enable");
        @(negedge clk); slv_sum = 1;
        chk(0, 2'd0, 16'h0003, "R8 slave bit set");
        do_write(2'd1, 16'h0002);
        chk(0, 2'd1, 16'h0002, "R9 top enable slave");
        chk(1, 2'd0, 16'h0001, "R9 irq from slave");
        @(negedge clk); slv_sum = 0;
        chk(0, 2'd0, 16'h0001, "R8 slave bit drops");
        chk(1, 2'd0, 16'h0000, "R9 irq drops with slave");

        // R11 unmapped bits
        do_write(2'd1, 16'hFFFF);
        chk(0, 2'd1, 16'h0003, "R11 top enable width");
        do_write(2'd0, 16'hFFFE);
        chk(0, 2'd0, 16'h0001, "R11 top status upper write ignored");

        #5;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule